// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog counter that advances on its own count enable, whatever the processor is doing. Software keeps it from expiring by writing a two-step key to a key register over a simple single-cycle register-write port. The first value, 55h, arms the block. The second value, AAh, clears the counter, but only if the block is armed. Any other key value raises a reset request at once.

When the counter reaches its timeout, the block either pulses a reset request or raises a held interrupt, as a mode bit selects. A control register can disable the watchdog. A sticky status flag records that the watchdog asked for a reset; software clears it by writing a one to it.

The block comes out of reset enabled and in reset mode. Software must therefore service it or disable it before the first timeout.

Top module: `key_watchdog`

## Requirements
- R1: The counter changes only on a cycle with `tick_i` high, unless a valid clear or the disable control acts on it. Register writes and idle cycles leave `count_o` unchanged.
- R2: On the `TIMEOUT`-th tick after the last clear, `count_o` wraps to 0 and the block signals a timeout. In reset mode the timeout shows as `rst_req_o` high in the cycle after that tick's edge. `count_o` never reaches `TIMEOUT`.
- R3: If the block is armed, a write of AAh to the key register (address 0) sets `count_o` to 0.
- R4: A write of AAh while the block is not armed has no effect on the counter and raises no reset.
- R5: Writing 55h arms the block, and more 55h writes keep it armed without a reset. A successful AAh clear disarms the block, so the next AAh write has no effect.
- R6: Writing any key value other than 55h or AAh while the block is enabled raises `rst_req_o` in the next cycle. The counter is left as it was.
- R7: `rst_req_o` is a single-cycle pulse for each reset event.
- R8: Control bit 1 (address 1) set to 1 selects interrupt mode. In interrupt mode a timeout sets `irq_o` and raises no reset. `irq_o` stays high until a cycle with `irq_ack_i` high.
- R9: Control bit 0 (address 1) set to 1 disables the block. While disabled, `count_o` is held at 0, and neither a timeout nor a bad key value produces a reset, an interrupt or a status change.
- R10: `rst_flag_o` goes high together with every `rst_req_o` pulse and stays high. Writing to address 2 with bit 0 set clears it; writing a 0 in that bit leaves it unchanged.
- R11: After reset, `count_o`=0, `rst_req_o`=0, `irq_o`=0 and `rst_flag_o`=0. The block starts enabled and in reset mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 key, 1 control, 2 status |
| wr_data_i | input | 8 | Write data |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| count_o | output | CNT_W | Current counter value |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Timeout interrupt, held |
| rst_flag_o | output | 1 | Sticky watchdog-reset status |

## Verification
The assertions assume that a write lasts exactly one cycle with a stable address and data. They also assume that `tick_i` and `irq_ack_i` are synchronous one-cycle levels, so the key, tick and acknowledge inputs are sampled once per edge. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It never issues a write to address 3, so the properties only see the three defined registers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  localparam int unsigned KEY_W   = 8;
  localparam logic [KEY_W-1:0] KEY_ARM = 8'h55;
  localparam logic [KEY_W-1:0] KEY_CLR = 8'hAA;
  localparam int unsigned CTRL_DIS_BIT = 0;
  localparam int unsigned CTRL_IRQ_BIT = 1;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_data_i,
  input  logic             dis_i,
  output logic             armed_o,
  output logic             clr_o,
  output logic             bad_o
);
  logic armed_q;
  logic act, is_arm, is_clr;

  assign act    = key_wr_i & ~dis_i;
  assign is_arm = key_data_i == KEY_ARM;
  assign is_clr = key_data_i == KEY_CLR;
  assign clr_o  = act & is_clr & armed_q;
  assign bad_o  = act & ~is_arm & ~is_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (dis_i)  armed_q <= 1'b0;
    else if (act)    armed_q <= is_arm ? 1'b1 : (is_clr ? 1'b0 : 1'b0);
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TIMEOUT = 256,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             dis_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap  = cnt_q == LAST;
  assign ovf_o = tick_i & wrap & ~clr_i & ~dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (dis_i || clr_i)   cnt_q <= '0;
    else if (tick_i)           cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_wr_i,
  input  logic [1:0] ctrl_data_i,
  input  logic       stat_w1c_i,
  input  logic       bad_key_i,
  input  logic       ovf_i,
  input  logic       irq_ack_i,
  output logic       dis_o,
  output logic       irq_sel_o,
  output logic       rst_req_o,
  output logic       irq_o,
  output logic       rst_flag_o
);
  import wdt_pkg::*;

  logic dis_q, irq_sel_q, rst_req_q, irq_q, flag_q;
  logic rst_evt, irq_evt;

  assign rst_evt = bad_key_i | (ovf_i & ~irq_sel_q);
  assign irq_evt = ovf_i & irq_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q     <= 1'b0;
      irq_sel_q <= 1'b0;
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        dis_q     <= ctrl_data_i[CTRL_DIS_BIT];
        irq_sel_q <= ctrl_data_i[CTRL_IRQ_BIT];
      end
      rst_req_q <= rst_evt;
      if (irq_evt)        irq_q <= 1'b1;
      else if (irq_ack_i) irq_q <= 1'b0;
      if (rst_evt)         flag_q <= 1'b1;
      else if (stat_w1c_i) flag_q <= 1'b0;
    end
  end

  assign dis_o      = dis_q;
  assign irq_sel_o  = irq_sel_q;
  assign rst_req_o  = rst_req_q;
  assign irq_o      = irq_q;
  assign rst_flag_o = flag_q;
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT = 256,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             irq_ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o,
  output logic             irq_o,
  output logic             rst_flag_o
);
  logic key_wr, ctrl_wr, stat_w1c;
  logic wd_dis, irq_sel, key_armed, key_clr, key_bad, ovf;

  assign key_wr   = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_KEY);
  assign ctrl_wr  = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_CTRL);
  assign stat_w1c = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_STAT) && wr_data_i[0];

  wdt_key_seq u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr),
    .key_data_i (wr_data_i),
    .dis_i      (wd_dis),
    .armed_o    (key_armed),
    .clr_o      (key_clr),
    .bad_o      (key_bad)
  );

  wdt_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clr_i   (key_clr),
    .dis_i   (wd_dis),
    .count_o (count_o),
    .ovf_o   (ovf)
  );

  wdt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_data_i (wr_data_i[1:0]),
    .stat_w1c_i  (stat_w1c),
    .bad_key_i   (key_bad),
    .ovf_i       (ovf),
    .irq_ack_i   (irq_ack_i),
    .dis_o       (wd_dis),
    .irq_sel_o   (irq_sel),
    .rst_req_o   (rst_req_o),
    .irq_o       (irq_o),
    .rst_flag_o  (rst_flag_o)
  );
endmodule

// File: rtl/key_watchdog_chk.sv
module key_watchdog_chk #(
  parameter int unsigned TIMEOUT = 256,
  localparam int unsigned CNT_W  = $clog2(TIMEOUT)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [7:0]       wr_data_i,
  input logic             irq_ack_i,
  input logic [CNT_W-1:0] count_o,
  input logic             rst_req_o,
  input logic             irq_o,
  input logic             rst_flag_o,
  input logic             wd_dis,
  input logic             irq_sel,
  input logic             key_armed,
  input logic             key_clr
);
  logic key_wr;
  assign key_wr = wr_en_i && wr_addr_i == 2'd0;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !key_clr && !wd_dis) |=> $stable(count_o)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_o) < TIMEOUT); // R2
  AST_UNARMED_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wr_data_i == 8'hAA && !key_armed && !tick_i && !wd_dis) |=> $stable(count_o)); // R4
  AST_BAD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && wr_data_i != 8'h55 && wr_data_i != 8'hAA && !wd_dis) |=> rst_req_o); // R6
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o); // R8
  AST_IRQ_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sel && !key_wr) |=> !rst_req_o); // R8
  AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_dis |=> (count_o == '0)); // R9
  AST_FLAG_WITH_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rst_flag_o); // R10
endmodule

bind key_watchdog key_watchdog_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .irq_ack_i  (irq_ack_i),
  .count_o    (count_o),
  .rst_req_o  (rst_req_o),
  .irq_o      (irq_o),
  .rst_flag_o (rst_flag_o),
  .wd_dis     (wd_dis),
  .irq_sel    (irq_sel),
  .key_armed  (key_armed),
  .key_clr    (key_clr)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  localparam int unsigned TO = 8;
  localparam int unsigned CW = $clog2(TO);

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] data = '0;
  logic [CW-1:0] count;
  logic rst_req, irq, flag;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  key_watchdog #(.TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(addr), .wr_data_i(data), .irq_ack_i(ack),
    .count_o(count), .rst_req_o(rst_req), .irq_o(irq), .rst_flag_o(flag)
  );

  // {op(0 write,1 tick), addr, data, expected count, expected rst_req}
  localparam logic [16:0] VEC [12] = '{
    {2'd1, 2'd0, 8'h00, 4'd1, 1'b0},
    {2'd1, 2'd0, 8'h00, 4'd2, 1'b0},
    {2'd1, 2'd0, 8'h00, 4'd3, 1'b0},
    {2'd0, 2'd0, 8'hAA, 4'd3, 1'b0},  // R4 unarmed clear ignored
    {2'd0, 2'd0, 8'h55, 4'd3, 1'b0},
    {2'd0, 2'd0, 8'h55, 4'd3, 1'b0},  // R5 repeated arm
    {2'd1, 2'd0, 8'h00, 4'd4, 1'b0},
    {2'd0, 2'd0, 8'hAA, 4'd0, 1'b0},  // R3 armed clear
    {2'd1, 2'd0, 8'h00, 4'd1, 1'b0},
    {2'd0, 2'd0, 8'hAA, 4'd1, 1'b0},  // R5 arm consumed
    {2'd0, 2'd0, 8'h12, 4'd1, 1'b1},  // R6 bad key
    {2'd1, 2'd0, 8'h00, 4'd2, 1'b0}   // R7 pulse gone
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 count", int'(count), 0);
    check("R11 rst_req", int'(rst_req), 0);
    check("R11 irq", int'(irq), 0);
    check("R11 flag", int'(flag), 0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][16:15] == 2'd1) ticks(1);
      else wr(VEC[i][14:13], VEC[i][12:5]);
      check($sformatf("R3/R4/R5/R6/R7 vec%0d count", i), int'(count), int'(VEC[i][4:1]));
      check($sformatf("R6/R7 vec%0d rst_req", i), int'(rst_req), int'(VEC[i][0]));
    end

    // R10 sticky flag, W1C
    check("R10 flag set", int'(flag), 1);
    wr(2'd2, 8'h00);
    check("R10 write 0 keeps", int'(flag), 1);
    wr(2'd2, 8'h01);
    check("R10 w1c clears", int'(flag), 0);

    // R1 idle cycles and control rewrites leave count
    repeat (5) @(negedge clk);
    check("R1 idle hold", int'(count), 2);
    wr(2'd1, 8'h00);
    check("R1 ctrl write hold", int'(count), 2);

    // R2 overflow in reset mode
    wr(2'd0, 8'h55); wr(2'd0, 8'hAA);
    check("R3 clear", int'(count), 0);
    ticks(TO - 1);
    check("R2 before timeout count", int'(count), TO - 1);
    check("R2 before timeout rst", int'(rst_req), 0);
    ticks(1);
    check("R2 wrap count", int'(count), 0);
    check("R2 timeout rst", int'(rst_req), 1);
    check("R10 flag on timeout", int'(flag), 1);
    check("R2 no irq in reset mode", int'(irq), 0);
    @(negedge clk);
    check("R7 single cycle", int'(rst_req), 0);

    // R8 interrupt mode
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h02);
    ticks(TO);
    check("R8 irq set", int'(irq), 1);
    check("R8 no rst", int'(rst_req), 0);
    check("R8 flag untouched", int'(flag), 0);
    repeat (3) @(negedge clk);
    check("R8 irq held", int'(irq), 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check("R8 irq acked", int'(irq), 0);

    // R9 disable
    ticks(3);
    check("R9 pre count", int'(count), 3);
    wr(2'd1, 8'h01);
    @(negedge clk);
    check("R9 held zero", int'(count), 0);
    ticks(2 * TO + 3);
    check("R9 no count", int'(count), 0);
    check("R9 no irq", int'(irq), 0);
    check("R9 no rst", int'(rst_req), 0);
    wr(2'd0, 8'h33);
    check("R9 bad key ignored", int'(rst_req), 0);
    check("R9 flag ignored", int'(flag), 0);
    wr(2'd1, 8'h00);
    ticks(2);
    check("R9 re-enabled count", int'(count), 2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule